// File: doc/BRIEF.md
# Two-Word Pixel Input Demultiplexer

This block receives a video word stream from a graphics source in which every pixel is split into two consecutive words: a first word "a" and a second word "b". The stream runs at twice the pixel rate. It arrives with a horizontal sync and a data enable. The block captures each word on the rising clock edge, on the falling edge, or on both edges. It joins the word pairs into whole pixels and unpacks each pixel onto a 24-bit bus, with a one-cycle valid strobe. The sync and the enable are delayed so that they stay aligned with the pixel.

Each horizontal sync leading edge restarts the word pairing, so the word after that edge is always treated as word "a". Five packing codes are supported:

- RGB with 8 bits per component, split across two 12-bit words.
- RGB 5-6-5, split across two bytes.
- RGB 5-5-5, split across two bytes.
- A width-dependent alias of one of the formats above.
- YCbCr 4:2:2 in chroma-first order. Chroma is held between the two luma samples of a pair, which gives one full-colour pixel per luma sample.

While the enable is low, the pixel bus carries the blank level of the selected format.

Top module: `pix_demux`

## Requirements
- R1: While `rst` is high at a rising edge, the outputs that follow are `pix_valid`=0, `pix_de`=0, `pix_hs`=0 and `pix_out`=0.
- R2: In single-edge modes, two consecutive enabled words produce exactly one `pix_valid` pulse, one cycle long. No two valid cycles are adjacent.
- R3: In rising-edge mode, suppose word "b" is sampled at rising edge k. Then `pix_valid` is high in the cycle after edge k+1, and `pix_de` is high in that same cycle.
- R4: `fmt` codes 0, 5, 6 and 7 select RGB 8-8-8. Word a bits [11:8] give G[3:0] and bits [7:0] give B. Word b bits [11:4] give R and bits [3:0] give G[7:4]. The output is `pix_out` = {R,G,B}, with R in bits [23:16].
- R5: `fmt` code 1 is the same as code 0 when W is at least 12. Otherwise it is the same as code 2.
- R6: `fmt` code 2 is RGB 5-6-5. The packed value P = {b[7:0], a[7:0]} holds R=P[15:11], G=P[10:5] and B=P[4:0]. Each component is widened to 8 bits by repeating its top bits. Word bits above 7 are ignored.
- R7: `fmt` code 3 is RGB 5-5-5, with R=P[14:10], G=P[9:5] and B=P[4:0]. Each component is widened the same way as in R6. P[15] is ignored.
- R8: `fmt` code 4 is YCbCr. Word a holds chroma and word b holds luma. Chroma alternates Cb, Cr, starting with Cb after each sync leading edge. The output is {Y, Cb, Cr}, using the newest chroma and the held value of the other component. Both held values reset to 128 on a sync leading edge.
- R9: While `pix_de` is low, `pix_out` is 0 for RGB codes and 24'h108080 for code 4.
- R10: A word "a" followed by a word with the enable low is discarded, and the pairing restarts at word "a".
- R11: A sample in which the sync is first seen high is discarded, and the next enabled word is treated as word "a".
- R12: With `cfg_fall`=1 and `cfg_both`=0, words are sampled on the falling clock edge only.
- R13: With `cfg_both`=1, word "a" is sampled on a rising edge and word "b" on the following falling edge. This yields one pixel per clock cycle, and a pixel needs the enable high on both words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input word clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fall | input | 1 | Single-edge capture on the falling edge |
| cfg_both | input | 1 | Capture on both edges |
| fmt | input | 3 | Packing format code |
| vin_data | input | W | Multiplexed input word |
| vin_hs | input | 1 | Horizontal sync, active high |
| vin_de | input | 1 | Input data enable |
| pix_out | output | 24 | Unpacked pixel |
| pix_valid | output | 1 | One-cycle pixel strobe |
| pix_hs | output | 1 | Delayed sync |
| pix_de | output | 1 | Delayed enable |

## Verification
The bench builds the block with its default W=12, so the 12-bit 8-8-8 layout is reachable and code 1 takes its wide alias. Byte formats are driven on the low bits of the 12-bit words, with junk in the upper bits to show that those bits are ignored. Falling-edge capture is exercised by driving a false word during the rising-edge sample. Both-edge capture is exercised by changing the data on every half cycle.

// File: rtl/pxd_pkg.sv
package pxd_pkg;

    localparam logic [2:0] FMT_RGB888 = 3'd0;
    localparam logic [2:0] FMT_ALIAS  = 3'd1;
    localparam logic [2:0] FMT_RGB565 = 3'd2;
    localparam logic [2:0] FMT_RGB555 = 3'd3;
    localparam logic [2:0] FMT_YCC    = 3'd4;

    localparam logic [7:0] LUMA_BLANK   = 8'd16;
    localparam logic [7:0] CHROMA_BLANK = 8'd128;

    function automatic logic [7:0] grow5(input logic [4:0] v);
        return {v, v[4:2]};
    endfunction

    function automatic logic [7:0] grow6(input logic [5:0] v);
        return {v, v[5:4]};
    endfunction

    function automatic logic [23:0] blank_of(input logic [2:0] f);
        return (f == FMT_YCC) ? {LUMA_BLANK, CHROMA_BLANK, CHROMA_BLANK} : 24'd0;
    endfunction

endpackage

// File: rtl/pxd_capture.sv
module pxd_capture #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    input  logic         hs,
    input  logic         de,
    output logic [W-1:0] r_w,
    output logic         r_hs,
    output logic         r_de,
    output logic [W-1:0] f_w,
    output logic         f_hs,
    output logic         f_de
);

    always_ff @(posedge clk) begin
        if (rst) begin
            r_w  <= '0;
            r_hs <= 1'b0;
            r_de <= 1'b0;
        end else begin
            r_w  <= din;
            r_hs <= hs;
            r_de <= de;
        end
    end

    always_ff @(negedge clk) begin
        if (rst) begin
            f_w  <= '0;
            f_hs <= 1'b0;
            f_de <= 1'b0;
        end else begin
            f_w  <= din;
            f_hs <= hs;
            f_de <= de;
        end
    end

endmodule

// File: rtl/pxd_unpack.sv
module pxd_unpack
    import pxd_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [2:0]   fmt,
    input  logic [W-1:0] word_a,
    input  logic [W-1:0] word_b,
    output logic [23:0]  rgb
);

    logic [11:0] wa, wb;
    logic [15:0] packed16;
    logic [23:0] rgb888, rgb565, rgb555, alias_rgb;

    always_comb begin
        wa       = 12'(word_a);
        wb       = 12'(word_b);
        packed16 = {wb[7:0], wa[7:0]};
        rgb888   = {wb[11:4], wb[3:0], wa[11:8], wa[7:0]};
        rgb565   = {grow5(packed16[15:11]), grow6(packed16[10:5]), grow5(packed16[4:0])};
        rgb555   = {grow5(packed16[14:10]), grow5(packed16[9:5]), grow5(packed16[4:0])};
    end

    generate
        if (W >= 12) begin : g_wide_alias
            assign alias_rgb = rgb888;
        end else begin : g_narrow_alias
            assign alias_rgb = rgb565;
        end
    endgenerate

    always_comb begin
        case (fmt)
            FMT_ALIAS:  rgb = alias_rgb;
            FMT_RGB565: rgb = rgb565;
            FMT_RGB555: rgb = rgb555;
            default:    rgb = rgb888;
        endcase
    end

endmodule

// File: rtl/pxd_core.sv
module pxd_core
    import pxd_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_fall,
    input  logic         cfg_both,
    input  logic [2:0]   fmt,
    input  logic [W-1:0] r_w,
    input  logic         r_hs,
    input  logic         r_de,
    input  logic [W-1:0] f_w,
    input  logic         f_hs,
    input  logic         f_de,
    output logic [23:0]  pix,
    output logic         vld,
    output logic         hs_o,
    output logic         de_o
);

    typedef struct packed {
        logic         phase_b;
        logic [W-1:0] a_word;
        logic         hs_prev;
        logic         odd;
        logic [7:0]   cb;
        logic [7:0]   cr;
        logic [23:0]  pix;
        logic         vld;
        logic         hs_o;
        logic         de_o;
    } st_t;

    st_t st_q, st_d;

    logic [W-1:0] s_w, pa, pb;
    logic         s_hs, s_de;
    logic [23:0]  rgb;

    always_comb begin
        s_w  = cfg_fall ? f_w  : r_w;
        s_hs = cfg_fall ? f_hs : r_hs;
        s_de = cfg_fall ? f_de : r_de;
        pa   = cfg_both ? r_w : st_q.a_word;
        pb   = cfg_both ? f_w : s_w;
    end

    pxd_unpack #(.W(W)) u_unpack (
        .fmt    (fmt),
        .word_a (pa),
        .word_b (pb),
        .rgb    (rgb)
    );

    always_comb begin
        logic       hs_now, de_now, lead, done;
        logic [7:0] chroma, luma;

        st_d     = st_q;
        st_d.vld = 1'b0;
        done     = 1'b0;
        hs_now   = cfg_both ? r_hs : s_hs;
        de_now   = cfg_both ? (r_de & f_de) : s_de;
        lead     = hs_now & ~st_q.hs_prev;
        chroma   = pa[7:0];
        luma     = pb[7:0];

        st_d.hs_prev = hs_now;

        if (cfg_both) begin
            st_d.phase_b = 1'b0;
            done         = de_now & ~lead;
        end else if (lead || !de_now) begin
            st_d.phase_b = 1'b0;
        end else if (!st_q.phase_b) begin
            st_d.phase_b = 1'b1;
            st_d.a_word  = s_w;
        end else begin
            st_d.phase_b = 1'b0;
            done         = 1'b1;
        end

        if (lead) begin
            st_d.odd = 1'b0;
            st_d.cb  = CHROMA_BLANK;
            st_d.cr  = CHROMA_BLANK;
        end

        if (done) begin
            st_d.vld = 1'b1;
            if (fmt == FMT_YCC) begin
                if (!st_q.odd) begin
                    st_d.cb  = chroma;
                    st_d.pix = {luma, chroma, st_q.cr};
                end else begin
                    st_d.cr  = chroma;
                    st_d.pix = {luma, st_q.cb, chroma};
                end
                st_d.odd = ~st_q.odd;
            end else begin
                st_d.pix = rgb;
            end
        end else if (!de_now) begin
            st_d.pix = blank_of(fmt);
        end

        st_d.hs_o = hs_now;
        st_d.de_o = de_now;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            st_q.cb <= CHROMA_BLANK;
            st_q.cr <= CHROMA_BLANK;
        end else begin
            st_q <= st_d;
        end
    end

    assign pix  = st_q.pix;
    assign vld  = st_q.vld;
    assign hs_o = st_q.hs_o;
    assign de_o = st_q.de_o;

endmodule

// File: rtl/pix_demux.sv
module pix_demux #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cfg_fall,
    input  logic         cfg_both,
    input  logic [2:0]   fmt,
    input  logic [W-1:0] vin_data,
    input  logic         vin_hs,
    input  logic         vin_de,
    output logic [23:0]  pix_out,
    output logic         pix_valid,
    output logic         pix_hs,
    output logic         pix_de
);

    logic [W-1:0] r_w, f_w;
    logic         r_hs, r_de, f_hs, f_de;

    pxd_capture #(.W(W)) u_capture (
        .clk  (clk),
        .rst  (rst),
        .din  (vin_data),
        .hs   (vin_hs),
        .de   (vin_de),
        .r_w  (r_w),
        .r_hs (r_hs),
        .r_de (r_de),
        .f_w  (f_w),
        .f_hs (f_hs),
        .f_de (f_de)
    );

    pxd_core #(.W(W)) u_core (
        .clk      (clk),
        .rst      (rst),
        .cfg_fall (cfg_fall),
        .cfg_both (cfg_both),
        .fmt      (fmt),
        .r_w      (r_w),
        .r_hs     (r_hs),
        .r_de     (r_de),
        .f_w      (f_w),
        .f_hs     (f_hs),
        .f_de     (f_de),
        .pix      (pix_out),
        .vld      (pix_valid),
        .hs_o     (pix_hs),
        .de_o     (pix_de)
    );

endmodule

// File: rtl/pix_demux_chk.sv
module pix_demux_chk (
    input logic        clk,
    input logic        rst,
    input logic        cfg_both,
    input logic [2:0]  fmt,
    input logic [23:0] pix_out,
    input logic        pix_valid,
    input logic        pix_hs,
    input logic        pix_de
);

    logic rst_seen;

    always_ff @(posedge clk) rst_seen <= rst;

    // R1: outputs cleared after a reset edge
    always @(negedge clk) begin
        if (rst_seen === 1'b1) begin
            a_r1_reset_clears: assert (!pix_valid && !pix_de && !pix_hs && pix_out == 24'd0)
                else $error("reset state wrong");
        end
    end

    a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
        (pix_valid && !cfg_both) |=> !pix_valid);

    a_r3_valid_has_de: assert property (@(posedge clk) disable iff (rst)
        pix_valid |-> pix_de);

    a_r9_blank_level: assert property (@(posedge clk) disable iff (rst)
        (!pix_de && !$past(rst)) |-> pix_out == (($past(fmt) == 3'd4) ? 24'h108080 : 24'h000000));

endmodule

bind pix_demux pix_demux_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_both  (cfg_both),
    .fmt       (fmt),
    .pix_out   (pix_out),
    .pix_valid (pix_valid),
    .pix_hs    (pix_hs),
    .pix_de    (pix_de)
);

// File: tb/tb_pix_demux.sv
module tb_pix_demux;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_fall = 1'b0, cfg_both = 1'b0;
    logic [2:0]  fmt = 3'd0;
    logic [11:0] d = '0;
    logic        hs = 1'b0, de = 1'b0;
    logic [23:0] pix_out;
    logic        pix_valid, pix_hs, pix_de;

    int n_chk = 0, n_err = 0, nv = 0, base = 0;
    logic [23:0] got [0:15];
    bit done_flag = 0;

    always #4 clk = ~clk;

    pix_demux dut (
        .clk(clk), .rst(rst), .cfg_fall(cfg_fall), .cfg_both(cfg_both), .fmt(fmt),
        .vin_data(d), .vin_hs(hs), .vin_de(de),
        .pix_out(pix_out), .pix_valid(pix_valid), .pix_hs(pix_hs), .pix_de(pix_de)
    );

    always @(posedge clk) begin
        #1;
        if (pix_valid === 1'b1) begin
            got[nv % 16] = pix_out;
            nv++;
        end
    end

    typedef struct packed {
        logic [2:0]  f;
        logic [11:0] a;
        logic [11:0] b;
        logic [23:0] e;
    } vec_t;

    localparam vec_t TBL [0:7] = '{
        '{3'd0, 12'h5A3, 12'hC7E, 24'hC7E5A3},  // R4
        '{3'd1, 12'h123, 12'h456, 24'h456123},  // R5
        '{3'd2, 12'hF34, 12'h3A5, 24'hA5A6A5},  // R6 upper bits junk
        '{3'd2, 12'h000, 12'h0F8, 24'hFF0000},  // R6
        '{3'd2, 12'h0E0, 12'h007, 24'h00FF00},  // R6
        '{3'd3, 12'h01F, 12'h0FC, 24'hFF00FF},  // R7 bit 15 set
        '{3'd3, 12'h04A, 12'h029, 24'h525252},  // R7
        '{3'd6, 12'h5A3, 12'hC7E, 24'hC7E5A3}   // R4 spare code
    };

    function automatic string tag_of(input logic [2:0] f);
        case (f)
            3'd1:    return "R5";
            3'd2:    return "R6";
            3'd3:    return "R7";
            default: return "R4";
        endcase
    endfunction

    task automatic chk(input string req, input logic [23:0] act, input logic [23:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(input logic [11:0] w, input logic h, input logic e);
        @(posedge clk); #2;
        d = w; hs = h; de = e;
        if (cfg_fall) begin
            @(negedge clk); #2;
            d = ~w;
        end
    endtask

    task automatic pair_both(input logic [11:0] a, input logic [11:0] b, input logic e);
        @(negedge clk); #2;
        d = a; de = e; hs = 1'b0;
        @(posedge clk); #2;
        d = b;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) put(12'h000, 1'b0, 1'b0);
    endtask

    task automatic finish_run();
        if (!done_flag) begin
            done_flag = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1 valid", {23'd0, pix_valid}, 24'd0);
        chk("R1 de", {23'd0, pix_de}, 24'd0);
        chk("R1 hs", {23'd0, pix_hs}, 24'd0);
        chk("R1 pix", pix_out, 24'd0);
        @(posedge clk); #2;
        rst = 1'b0;
        idle(3);

        // table of formats, rising-edge capture
        for (int i = 0; i < 8; i++) begin
            fmt  = TBL[i].f;
            base = nv;
            put(TBL[i].a, 1'b0, 1'b1);
            put(TBL[i].b, 1'b0, 1'b1);
            idle(3);
            chk({tag_of(TBL[i].f), " R2 count"}, 24'(nv - base), 24'd1);
            chk(tag_of(TBL[i].f), got[base % 16], TBL[i].e);
        end

        // R9 RGB blank level
        chk("R9 rgb blank", pix_out, 24'h000000);
        chk("R9 de low", {23'd0, pix_de}, 24'd0);

        // R3 latency
        fmt = 3'd0;
        put(12'h5A3, 1'b0, 1'b1);
        put(12'hC7E, 1'b0, 1'b1);
        @(posedge clk); #1;
        chk("R3 early", {23'd0, pix_valid}, 24'd0);
        #1; d = 12'h000; de = 1'b0;
        @(posedge clk); #1;
        chk("R3 valid", {23'd0, pix_valid}, 24'd1);
        chk("R3 de", {23'd0, pix_de}, 24'd1);
        @(posedge clk); #1;
        chk("R2 pulse end", {23'd0, pix_valid}, 24'd0);
        idle(2);

        // R10 enable drop mid-pair
        base = nv;
        put(12'h111, 1'b0, 1'b1);
        put(12'h000, 1'b0, 1'b0);
        put(12'h5A3, 1'b0, 1'b1);
        put(12'hC7E, 1'b0, 1'b1);
        idle(3);
        chk("R10 count", 24'(nv - base), 24'd1);
        chk("R10 pix", got[base % 16], 24'hC7E5A3);

        // R11 sync realign
        base = nv;
        put(12'h777, 1'b0, 1'b1);
        put(12'h888, 1'b1, 1'b1);
        put(12'h5A3, 1'b1, 1'b1);
        put(12'hC7E, 1'b1, 1'b1);
        idle(3);
        chk("R11 count", 24'(nv - base), 24'd1);
        chk("R11 pix", got[base % 16], 24'hC7E5A3);

        // R8 YCbCr with chroma hold
        fmt  = 3'd4;
        put(12'h000, 1'b1, 1'b0);
        put(12'h000, 1'b0, 1'b0);
        base = nv;
        put(12'h040, 1'b0, 1'b1); put(12'h050, 1'b0, 1'b1);
        put(12'h060, 1'b0, 1'b1); put(12'h070, 1'b0, 1'b1);
        put(12'h044, 1'b0, 1'b1); put(12'h055, 1'b0, 1'b1);
        put(12'h066, 1'b0, 1'b1); put(12'h077, 1'b0, 1'b1);
        idle(3);
        chk("R8 count", 24'(nv - base), 24'd4);
        chk("R8 p0", got[base % 16], 24'h504080);
        chk("R8 p1", got[(base + 1) % 16], 24'h704060);
        chk("R8 p2", got[(base + 2) % 16], 24'h554460);
        chk("R8 p3", got[(base + 3) % 16], 24'h774466);
        chk("R9 ycc blank", pix_out, 24'h108080);

        // R12 falling-edge capture, rising sample sees inverted junk
        fmt      = 3'd0;
        cfg_fall = 1'b1;
        idle(2);
        base = nv;
        put(12'h5A3, 1'b0, 1'b1);
        put(12'hC7E, 1'b0, 1'b1);
        idle(3);
        chk("R12 count", 24'(nv - base), 24'd1);
        chk("R12 pix", got[base % 16], 24'hC7E5A3);
        cfg_fall = 1'b0;
        idle(2);

        // R13 both-edge capture
        cfg_both = 1'b1;
        pair_both(12'h000, 12'h000, 1'b0);
        pair_both(12'h000, 12'h000, 1'b0);
        base = nv;
        pair_both(12'h5A3, 12'hC7E, 1'b1);
        pair_both(12'h123, 12'h456, 1'b1);
        for (int i = 0; i < 3; i++) pair_both(12'h000, 12'h000, 1'b0);
        chk("R13 count", 24'(nv - base), 24'd2);
        chk("R13 p0", got[base % 16], 24'hC7E5A3);
        chk("R13 p1", got[(base + 1) % 16], 24'h456123);

        finish_run();
    end

endmodule